// File: doc/BRIEF.md
# Indexed byte-store port with lock windows

This block puts a byte-addressed storage array behind a narrow four-offset port. The host never presents a full memory address. It first loads a 16-bit pointer one byte at a time through two pointer offsets, then moves data through a third offset. A data write stores the byte and returns the pointer to zero, so every write must be preceded by a fresh pointer load. A data read leaves the pointer where it is, so the same location can be polled repeatedly.

Two lock bits guard two adjacent 16-byte windows of the array, at 0x20..0x2F and 0x30..0x3F. While a window's bit is set, writes there are dropped and reads there return all ones. Pointer values at or beyond the array size behave the same way.

The lock bits are loaded as a whole through a separate strobe. Read data appears one cycle after the read strobe, together with a valid flag. The array size is a parameter.

Top module: `nvport_indexed`

## Requirements
- R1: A write with `off_i` = 0 replaces bits 7:0 of the pointer with `wdata_i` and keeps bits 15:8.
- R2: A write with `off_i` = 1 replaces bits 15:8 of the pointer with `wdata_i` and keeps bits 7:0.
- R3: A write with `off_i` = 3 stores `wdata_i` at the pointer address when that address is accessible. The pointer then becomes 0, whether or not the byte was stored.
- R4: A read with `off_i` = 3 returns the byte at the pointer address and leaves the pointer unchanged.
- R5: Reads with `off_i` of 0, 1 or 2 return 0xFF. A write with `off_i` = 2 changes neither the pointer nor the array.
- R6: While lock bit 0 is 1, pointer addresses 0x20..0x2F drop writes and read as 0xFF.
- R7: While lock bit 1 is 1, pointer addresses 0x30..0x3F drop writes and read as 0xFF.
- R8: A pointer address at or above `MEM_BYTES` drops writes and reads as 0xFF. Such a write does not alias onto a lower address.
- R9: `rvalid_o` is 1 in exactly the cycle after each cycle with `req_i`=1 and `we_i`=0. `rdata_o` carries the result in that cycle.
- R10: Reset clears the pointer, both lock bits and `rvalid_o`. It leaves the array contents unchanged.
- R11: When `lock_we_i` is 1, `lock_q` takes `lock_i` at the clock edge. A data access presented in that same cycle is judged against the lock value held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| off_i | input | 2 | Port offset: 0 pointer low, 1 pointer high, 2 unused, 3 data |
| wdata_i | input | 8 | Write data |
| lock_we_i | input | 1 | Load strobe for the lock bits |
| lock_i | input | NUM_LOCKS | New lock bits; bit k guards 0x20+16k..0x2F+16k |
| rvalid_o | output | 1 | Read result valid |
| rdata_o | output | 8 | Read result |

## Verification
A lock update and a data access can land on the same clock edge. Which lock value governs that access is the one ordering question this block has. The bench provokes it by raising `lock_we_i` in the same cycle as a read or a write inside a guarded window, in both directions (locking and unlocking). Its behavioural model judges the access against the lock bits held before the edge and applies the new bits afterwards. A follow-up access to the same address then shows that the new lock has taken effect.

// File: rtl/nvport_pkg.sv
package nvport_pkg;
  localparam int unsigned PTR_W      = 16;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned LOCK_BASE  = 32'h20;
  localparam int unsigned LOCK_SPAN  = 16;

  typedef enum logic [1:0] {
    OFF_PTR_LO = 2'd0,
    OFF_PTR_HI = 2'd1,
    OFF_RSVD   = 2'd2,
    OFF_DATA   = 2'd3
  } port_off_e;
endpackage

// File: rtl/nvport_ptr.sv
module nvport_ptr #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LANES = PTR_W / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PTR_W-1:0]  ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           ptr_q[g*DATA_W +: DATA_W] <= '0;
      else if (lane_we_i[g]) ptr_q[g*DATA_W +: DATA_W] <= wdata_i;
      else if (clr_i)        ptr_q[g*DATA_W +: DATA_W] <= '0;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/nvport_guard.sv
module nvport_guard #(
  parameter int unsigned PTR_W     = 16,
  parameter int unsigned MEM_BYTES = 2048,
  parameter int unsigned NUM_LOCKS = 2,
  parameter int unsigned LOCK_BASE = 32'h20,
  parameter int unsigned LOCK_SPAN = 16,
  localparam int unsigned AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [NUM_LOCKS-1:0] lock_i,
  output logic                 ok_o,
  output logic [AW-1:0]        idx_o
);
  logic [NUM_LOCKS-1:0] hit;
  logic                 in_range;
  logic [31:0]          ptr_ext;

  assign ptr_ext  = 32'(ptr_i);
  assign in_range = ptr_ext < MEM_BYTES;

  for (genvar k = 0; k < NUM_LOCKS; k++) begin : g_win
    localparam int unsigned LO = LOCK_BASE + k * LOCK_SPAN;
    localparam int unsigned HI = LO + LOCK_SPAN;
    assign hit[k] = lock_i[k] && (ptr_ext >= LO) && (ptr_ext < HI);
  end

  assign ok_o  = in_range && !(|hit);
  assign idx_o = ptr_i[AW-1:0];
endmodule

// File: rtl/nvport_mem.sv
module nvport_mem #(
  parameter int unsigned MEM_BYTES = 2048,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [MEM_BYTES];
  logic [DATA_W-1:0] rdata_q;

  // no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/nvport_indexed.sv
module nvport_indexed
  import nvport_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 2048,
  parameter int unsigned NUM_LOCKS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [1:0]           off_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 lock_we_i,
  input  logic [NUM_LOCKS-1:0] lock_i,
  output logic                 rvalid_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam int unsigned AW    = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
  localparam int unsigned LANES = PTR_W / DATA_W;

  port_off_e            off;
  logic                 wr, rd, data_wr, data_rd, access_ok;
  logic [LANES-1:0]     lane_we;
  logic [PTR_W-1:0]     ptr_q;
  logic [NUM_LOCKS-1:0] lock_q;
  logic [AW-1:0]        mem_idx;
  logic [DATA_W-1:0]    mem_rdata;
  logic                 rvalid_q, blank_q;

  assign off     = port_off_e'(off_i);
  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign data_wr = wr && (off == OFF_DATA);
  assign data_rd = rd && (off == OFF_DATA);

  // pointer lanes sit at offsets 0..LANES-1
  for (genvar g = 0; g < LANES; g++) begin : g_lane_dec
    assign lane_we[g] = wr && (off_i == 2'(g));
  end

  nvport_ptr #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lane_we_i (lane_we),
    .clr_i     (data_wr),
    .wdata_i   (wdata_i),
    .ptr_o     (ptr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_q <= '0;
    else if (lock_we_i) lock_q <= lock_i;
  end

  nvport_guard #(
    .PTR_W(PTR_W), .MEM_BYTES(MEM_BYTES), .NUM_LOCKS(NUM_LOCKS),
    .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
  ) u_guard (
    .ptr_i  (ptr_q),
    .lock_i (lock_q),
    .ok_o   (access_ok),
    .idx_o  (mem_idx)
  );

  nvport_mem #(.MEM_BYTES(MEM_BYTES), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (data_wr && access_ok),
    .re_i    (data_rd && access_ok),
    .addr_i  (mem_idx),
    .wdata_i (wdata_i),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      blank_q  <= 1'b1;
    end else begin
      rvalid_q <= rd;
      if (rd) blank_q <= !(data_rd && access_ok);
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = blank_q ? '1 : mem_rdata;
endmodule

// File: rtl/nvport_indexed_chk.sv
module nvport_indexed_chk
  import nvport_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 2048,
  parameter int unsigned NUM_LOCKS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [1:0]           off_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic [PTR_W-1:0]     ptr_i,
  input logic [NUM_LOCKS-1:0] lock_state_i,
  input logic                 rvalid_i,
  input logic [DATA_W-1:0]    rdata_i
);
  logic rd3, in_win0, in_win1, oob;
  assign rd3     = req_i && !we_i && (off_i == OFF_DATA);
  assign in_win0 = (32'(ptr_i) >= LOCK_BASE) && (32'(ptr_i) < LOCK_BASE + LOCK_SPAN);
  assign in_win1 = (32'(ptr_i) >= LOCK_BASE + LOCK_SPAN) && (32'(ptr_i) < LOCK_BASE + 2 * LOCK_SPAN);
  assign oob     = 32'(ptr_i) >= MEM_BYTES;

  a_r1_lo_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && off_i == OFF_PTR_LO |=>
      ptr_i[7:0] == $past(wdata_i) && ptr_i[15:8] == $past(ptr_i[15:8]));

  a_r2_hi_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && off_i == OFF_PTR_HI |=>
      ptr_i[15:8] == $past(wdata_i) && ptr_i[7:0] == $past(ptr_i[7:0]));

  a_r3_ptr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && off_i == OFF_DATA |=> ptr_i == '0);

  a_r4_read_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd3 |=> $stable(ptr_i));

  a_r5_other_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && off_i != OFF_DATA |=> rdata_i == 8'hFF);

  a_r5_rsvd_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && off_i == OFF_RSVD |=> $stable(ptr_i));

  a_r6_win0_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd3 && lock_state_i[0] && in_win0 |=> rdata_i == 8'hFF);

  a_r7_win1_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd3 && lock_state_i[NUM_LOCKS-1] && in_win1 |=> rdata_i == 8'hFF);

  a_r8_oob_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd3 && oob |=> rdata_i == 8'hFF);

  a_r9_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_i);

  a_r9_valid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_i);
endmodule

bind nvport_indexed nvport_indexed_chk #(
  .MEM_BYTES(MEM_BYTES), .NUM_LOCKS(NUM_LOCKS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .off_i        (off_i),
  .wdata_i      (wdata_i),
  .ptr_i        (ptr_q),
  .lock_state_i (lock_q),
  .rvalid_i     (rvalid_o),
  .rdata_i      (rdata_o)
);

// File: tb/nvport_indexed_tb.sv
module nvport_indexed_tb;
  localparam int MEM = 2048;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0, lock_we_i = 1'b0;
  logic [1:0] off_i = '0, lock_i = '0;
  logic [7:0] wdata_i = '0;
  logic       rvalid_o;
  logic [7:0] rdata_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int unsigned m_ptr = 0;
  bit [1:0]    m_lock = 0;
  bit [7:0]    m_mem [int];

  always #10 clk = ~clk;

  nvport_indexed #(.MEM_BYTES(MEM), .NUM_LOCKS(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .off_i(off_i),
    .wdata_i(wdata_i), .lock_we_i(lock_we_i), .lock_i(lock_i),
    .rvalid_o(rvalid_o), .rdata_o(rdata_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic bit allowed(input int unsigned a, input bit [1:0] lk);
    if (a >= MEM) return 0;
    if (lk[0] && a >= 32'h20 && a <= 32'h2F) return 0;
    if (lk[1] && a >= 32'h30 && a <= 32'h3F) return 0;
    return 1;
  endfunction

  // one access cycle; model judged with pre-edge lock, then lock updated (R11)
  task automatic op(input bit w, input bit [1:0] o, input bit [7:0] d,
                    input bit lw, input bit [1:0] lv, input string tag);
    bit [7:0] exp_d;
    @(negedge clk);
    req_i = 1'b1; we_i = w; off_i = o; wdata_i = d; lock_we_i = lw; lock_i = lv;
    exp_d = 8'hFF;
    if (w) begin
      case (o)
        2'd0: m_ptr = (m_ptr & 32'hFF00) | d;
        2'd1: m_ptr = (m_ptr & 32'h00FF) | (32'(d) << 8);
        2'd3: begin
          if (allowed(m_ptr, m_lock)) m_mem[m_ptr] = d;
          m_ptr = 0;
        end
        default: ;
      endcase
    end else if (o == 2'd3 && allowed(m_ptr, m_lock)) begin
      exp_d = m_mem.exists(m_ptr) ? m_mem[m_ptr] : 8'hxx;
    end
    if (lw) m_lock = lv;
    @(posedge clk); #5;
    chk({tag, " R9 valid"}, {7'd0, rvalid_o}, {7'd0, !w});
    if (!w) chk(tag, rdata_o, exp_d);
    req_i = 1'b0; lock_we_i = 1'b0;
  endtask

  task automatic wr(input bit [1:0] o, input bit [7:0] d, input string tag);
    op(1, o, d, 0, 0, tag);
  endtask
  task automatic rd(input bit [1:0] o, input string tag);
    op(0, o, 8'h00, 0, 0, tag);
  endtask
  task automatic set_ptr(input bit [15:0] a);
    wr(2'd0, a[7:0], "R1 ptr lo");
    wr(2'd1, a[15:8], "R2 ptr hi");
  endtask
  task automatic put(input bit [15:0] a, input bit [7:0] d);
    set_ptr(a);
    wr(2'd3, d, "R3 store");
  endtask
  task automatic set_lock(input bit [1:0] v);
    @(negedge clk);
    lock_we_i = 1'b1; lock_i = v;
    m_lock = v;
    @(negedge clk);
    lock_we_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 rvalid after reset", {7'd0, rvalid_o}, 8'd0);

    put(16'h0000, 8'h5A);
    put(16'h0010, 8'hA5);
    put(16'h0110, 8'h3C);
    put(16'h0123, 8'hC3);
    put(16'h0025, 8'h25);
    put(16'h0035, 8'h35);
    put(16'h07FF, 8'hEE);

    // R3: pointer zero after data write
    rd(2'd3, "R3 ptr cleared reads addr 0");
    // R4: repeated reads keep pointer
    set_ptr(16'h0010);
    rd(2'd3, "R4 read");
    rd(2'd3, "R4 read again");
    // R1/R2: byte replacement keeps other byte
    set_ptr(16'h0123);
    wr(2'd0, 8'h10, "R1 lo only");
    rd(2'd3, "R1 ptr 0110");
    wr(2'd1, 8'h00, "R2 hi only");
    rd(2'd3, "R2 ptr 0010");
    set_ptr(16'h07FF);
    rd(2'd3, "R8 last byte");
    // R5
    rd(2'd0, "R5 off0 read");
    rd(2'd1, "R5 off1 read");
    rd(2'd2, "R5 off2 read");
    set_ptr(16'h0123);
    wr(2'd2, 8'h77, "R5 off2 write");
    rd(2'd3, "R5 ptr kept after off2 write");
    // R6
    set_lock(2'b01);
    put(16'h0025, 8'h99);
    rd(2'd3, "R6 ptr cleared after blocked write");
    set_ptr(16'h0025);
    rd(2'd3, "R6 locked read");
    set_ptr(16'h0035);
    rd(2'd3, "R6 other window open");
    // R7
    set_lock(2'b10);
    put(16'h0035, 8'h88);
    set_ptr(16'h0035);
    rd(2'd3, "R7 locked read");
    set_ptr(16'h0025);
    rd(2'd3, "R7 win0 open, value kept");
    set_lock(2'b00);
    set_ptr(16'h0035);
    rd(2'd3, "R7 unlocked value kept");
    // R8
    put(16'h0800, 8'h11);
    set_ptr(16'h0800);
    rd(2'd3, "R8 oob read");
    set_ptr(16'hFFFF);
    rd(2'd3, "R8 top read");
    set_ptr(16'h0000);
    rd(2'd3, "R8 no alias");
    // R11: lock change same cycle as access
    set_ptr(16'h0025);
    op(0, 2'd3, 8'h00, 1, 2'b01, "R11 read with old lock");
    rd(2'd3, "R11 new lock applied");
    set_ptr(16'h0025);
    op(1, 2'd3, 8'h44, 1, 2'b00, "R11 write with old lock");
    set_ptr(16'h0025);
    rd(2'd3, "R11 write was blocked");
    set_ptr(16'h0025);
    op(1, 2'd3, 8'h66, 1, 2'b01, "R11 write before lock");
    set_lock(2'b00);
    set_ptr(16'h0025);
    rd(2'd3, "R11 write landed");
    // R10: mid-run reset
    set_lock(2'b11);
    set_ptr(16'h0025);
    @(negedge clk);
    rst_ni = 1'b0;
    m_ptr = 0; m_lock = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    chk("R10 rvalid in reset", {7'd0, rvalid_o}, 8'd0);
    rd(2'd3, "R10 ptr cleared, mem kept");
    set_ptr(16'h0025);
    rd(2'd3, "R10 lock cleared");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule